// File: doc/BRIEF.md
# Converter Byte-Bus Bridge

This block sits between a 10-bit successive-approximation converter, whose result appears on an 8-bit upper group and a 2-bit lower group that each have their own active-low enable, and a narrow processor bus with a byte-wide read path. The bridge decodes a window of three consecutive addresses starting at a parameterised base. Any write to the base address launches a conversion, whatever the data. A read of the base address fetches the upper eight result bits. A read of the next address fetches the two lowest bits, placed in the top two bits of the byte with the rest forced to zero. The third address returns a status byte.

The start signal is held by a flag that a one-cycle write sets. The flag clears only once the converter has reported, through its ready line, that its internal reset is done, and once a minimum number of cycles has passed. The ready line is brought through a synchroniser. Its falling edge, which marks the end of a conversion, raises a done interrupt. Reads that arrive while a conversion is running never open the converter's output groups. Such a read returns zero and records an error bit.

Top module: `adc_byte_bridge`

## Requirements
- R1: A one-cycle write strobe to the base address while the bridge is idle drives `cvt_start` high from the next clock edge on, for any value on `bus_wdata`.
- R2: A write to base+1, base+2 or an address outside the window leaves `cvt_start` low.
- R3: `cvt_start` stays high for at least `MIN_HIGH` cycles. It falls at the first edge where that count has been reached and a rising edge of the synchronised ready has been seen since the start.
- R4: A write to the base address while busy is ignored. Busy means `cvt_start` is high or the synchronised ready is high.
- R5: A read strobe to the base address while idle drives `hi_en_n` low for exactly the one cycle after the strobe. At the end of that cycle `rd_data` takes the value of `cvt_hi`.
- R6: A read strobe to base+1 while idle drives `lo_en_n` low for exactly one cycle. `rd_data` then becomes `{cvt_lo, 6'b000000}`, so the two result bits sit in bits 7..6 and bits 5..0 read as zero.
- R7: Neither enable is ever low while `cvt_start` or the synchronised ready is high. A read of base or base+1 while busy leaves both enables high, loads `rd_data` with 0x00 and sets the error bit.
- R8: A read of base+2 loads `rd_data` with a status byte laid out as follows:
  - bit 7: synchronised ready
  - bit 6: done
  - bit 5: error
  - bit 4: `cvt_start`
  - bits 3..0: zero

  The same read then clears the error bit.
- R9: `done_irq` rises one edge after the synchronised ready falls. It stays high until a non-busy base read captures the upper byte.
- R10: A read strobe that arrives in the capture cycle of the previous read is ignored. A read of an address outside the window loads 0x00.
- R11: After synchronous reset `cvt_start` and `done_irq` are 0, both enables are 1 and `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wdata | input | BUS_W | Write data, ignored |
| cvt_rdy | input | 1 | Converter ready line, high while converting (asynchronous) |
| cvt_hi | input | BUS_W | Converter upper result group |
| cvt_lo | input | LO_W | Converter lower result group |
| cvt_start | output | 1 | Convert pulse to converter |
| hi_en_n | output | 1 | Active-low enable of the upper group |
| lo_en_n | output | 1 | Active-low enable of the lower group |
| rd_data | output | BUS_W | Read data, held until next read |
| done_irq | output | 1 | Conversion-done interrupt |

## Verification
The bench builds the bridge with a two-stage synchroniser, `MIN_HIGH` of 4 and a base of 0x0C40. The converter ready latency is varied at run time. A latency of one cycle makes the minimum-width counter decide when the start pulse falls, and a latency of eight cycles makes the ready edge decide. The short conversion length keeps early reads, status reads during a conversion and back-to-back strobes within a few hundred cycles. Result codes include all-ones and all-zeros, so both byte groups and the left-justified low bits are exercised at their extremes.

// File: rtl/adcb_pkg.sv
package adcb_pkg;

  typedef enum logic [1:0] {
    SEL_HI   = 2'd0,
    SEL_LO   = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  localparam int STAT_BUSY_BIT = 7;
  localparam int STAT_DONE_BIT = 6;
  localparam int STAT_ERR_BIT  = 5;
  localparam int STAT_CVT_BIT  = 4;

endpackage

// File: rtl/adcb_ready_sync.sv
module adcb_ready_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic rdy_s,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] pipe;
  logic              rdy_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= raw;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-2:0], raw};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) rdy_d <= 1'b0;
    else     rdy_d <= pipe[STAGES-1];
  end

  assign rdy_s = pipe[STAGES-1];
  assign rise  = rdy_s & ~rdy_d;
  assign fall  = ~rdy_s & rdy_d;

  // R9: a detected fall always follows a cycle in which the line was high
  a_r9_fall_after_high: assert property (@(posedge clk) disable iff (rst)
    fall |-> $past(rdy_s));

endmodule

// File: rtl/adcb_convert_ctl.sv
module adcb_convert_ctl #(
  parameter int MIN_HIGH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic rdy_rise,
  output logic conv_q
);
  localparam int CW = (MIN_HIGH < 2) ? 1 : $clog2(MIN_HIGH);
  localparam logic [CW-1:0] CNT_LAST = CW'(MIN_HIGH - 1);

  logic [CW-1:0] cnt;
  logic          seen;
  logic          reached;

  assign reached = (cnt >= CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_q <= 1'b0;
      cnt    <= '0;
      seen   <= 1'b0;
    end else if (!conv_q) begin
      if (start_req) begin
        conv_q <= 1'b1;
        cnt    <= '0;
        seen   <= 1'b0;
      end
    end else if ((seen | rdy_rise) && reached) begin
      conv_q <= 1'b0;
    end else begin
      seen <= seen | rdy_rise;
      if (!reached) cnt <= cnt + 1'b1;
    end
  end

  // R3: the pulse never ends before its minimum width
  a_r3_min_width: assert property (@(posedge clk) disable iff (rst)
    $fell(conv_q) |-> ($past(cnt) == CNT_LAST));

  // R3: the pulse ends only after a ready rise was observed
  a_r3_needs_rise: assert property (@(posedge clk) disable iff (rst)
    $fell(conv_q) |-> ($past(seen) || $past(rdy_rise)));

endmodule

// File: rtl/adcb_read_path.sv
module adcb_read_path
  import adcb_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int LO_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd,
  input  sel_e             sel,
  input  logic             busy,
  input  logic [BUS_W-1:0] status,
  input  logic [BUS_W-1:0] hi_in,
  input  logic [LO_W-1:0]  lo_in,
  output logic             hi_en_n,
  output logic             lo_en_n,
  output logic [BUS_W-1:0] rd_data,
  output logic             cap_pend,
  output logic             hi_taken,
  output logic             err_set,
  output logic             stat_clr
);
  localparam int PAD_W = BUS_W - LO_W;

  logic cap_hi, cap_lo, accept, grp_sel;

  assign cap_pend = cap_hi | cap_lo;
  assign accept   = rd & ~cap_pend;
  assign grp_sel  = (sel == SEL_HI) || (sel == SEL_LO);
  assign hi_taken = cap_hi;
  assign err_set  = accept & grp_sel & busy;
  assign stat_clr = accept & (sel == SEL_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_en_n <= 1'b1;
      lo_en_n <= 1'b1;
      rd_data <= '0;
      cap_hi  <= 1'b0;
      cap_lo  <= 1'b0;
    end else begin
      cap_hi <= 1'b0;
      cap_lo <= 1'b0;
      if (cap_hi) begin
        rd_data <= hi_in;
        hi_en_n <= 1'b1;
      end
      if (cap_lo) begin
        rd_data <= {lo_in, {PAD_W{1'b0}}};
        lo_en_n <= 1'b1;
      end
      if (accept) begin
        case (sel)
          SEL_HI: begin
            if (busy) rd_data <= '0;
            else begin
              hi_en_n <= 1'b0;
              cap_hi  <= 1'b1;
            end
          end
          SEL_LO: begin
            if (busy) rd_data <= '0;
            else begin
              lo_en_n <= 1'b0;
              cap_lo  <= 1'b1;
            end
          end
          SEL_STAT: rd_data <= status;
          default:  rd_data <= '0;
        endcase
      end
    end
  end

  // R5: the upper enable opens for a single cycle
  a_r5_hi_one_cycle: assert property (@(posedge clk) disable iff (rst)
    !hi_en_n |=> hi_en_n);
  // R6: the lower enable opens for a single cycle
  a_r6_lo_one_cycle: assert property (@(posedge clk) disable iff (rst)
    !lo_en_n |=> lo_en_n);
  // R7: a read while busy returns zero and keeps both groups closed
  a_r7_early_zero: assert property (@(posedge clk) disable iff (rst)
    (accept && grp_sel && busy) |=> (rd_data == '0 && hi_en_n && lo_en_n));
  // R10: a strobe in the capture cycle opens no enable
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (rst)
    (rd && cap_pend) |=> (hi_en_n && lo_en_n));

endmodule

// File: rtl/adc_byte_bridge.sv
module adc_byte_bridge
  import adcb_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int unsigned BASE_ADDR   = 'h0C40,
  parameter int          BUS_W       = 8,
  parameter int          LO_W        = 2,
  parameter int          SYNC_STAGES = 2,
  parameter int          MIN_HIGH    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              cvt_rdy,
  input  logic [BUS_W-1:0]  cvt_hi,
  input  logic [LO_W-1:0]   cvt_lo,
  output logic              cvt_start,
  output logic              hi_en_n,
  output logic              lo_en_n,
  output logic [BUS_W-1:0]  rd_data,
  output logic              done_irq
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

  logic [ADDR_W-1:0] off;
  sel_e              sel;
  logic              rdy_s, rdy_rise, rdy_fall, busy;
  logic              start_req, cap_pend, hi_taken, err_set, stat_clr;
  logic              err_q;
  logic [BUS_W-1:0]  status;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata;

  assign off = bus_addr - BASE;
  always_comb begin
    if      (off == ADDR_W'(0)) sel = SEL_HI;
    else if (off == ADDR_W'(1)) sel = SEL_LO;
    else if (off == ADDR_W'(2)) sel = SEL_STAT;
    else                        sel = SEL_NONE;
  end

  assign busy      = cvt_start | rdy_s;
  assign start_req = bus_wr & (sel == SEL_HI) & ~busy & ~bus_rd & ~cap_pend;

  always_comb begin
    status                = '0;
    status[STAT_BUSY_BIT] = rdy_s;
    status[STAT_DONE_BIT] = done_irq;
    status[STAT_ERR_BIT]  = err_q;
    status[STAT_CVT_BIT]  = cvt_start;
  end

  adcb_ready_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .raw(cvt_rdy),
    .rdy_s(rdy_s), .rise(rdy_rise), .fall(rdy_fall)
  );

  adcb_convert_ctl #(.MIN_HIGH(MIN_HIGH)) u_conv (
    .clk(clk), .rst(rst), .start_req(start_req),
    .rdy_rise(rdy_rise), .conv_q(cvt_start)
  );

  adcb_read_path #(.BUS_W(BUS_W), .LO_W(LO_W)) u_rd (
    .clk(clk), .rst(rst), .rd(bus_rd), .sel(sel), .busy(busy),
    .status(status), .hi_in(cvt_hi), .lo_in(cvt_lo),
    .hi_en_n(hi_en_n), .lo_en_n(lo_en_n), .rd_data(rd_data),
    .cap_pend(cap_pend), .hi_taken(hi_taken),
    .err_set(err_set), .stat_clr(stat_clr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_irq <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (rdy_fall)      done_irq <= 1'b1;
      else if (hi_taken) done_irq <= 1'b0;
      if (err_set)       err_q <= 1'b1;
      else if (stat_clr) err_q <= 1'b0;
    end
  end

  // R7: enables stay closed through a conversion
  a_r7_en_closed_busy: assert property (@(posedge clk) disable iff (rst)
    (!hi_en_n || !lo_en_n) |-> (!cvt_start && !rdy_s));
  // R7: never both groups at once
  a_r7_one_group: assert property (@(posedge clk) disable iff (rst)
    (hi_en_n || lo_en_n));
  // R9: the interrupt rises only after a synchronised ready fall
  a_r9_irq_source: assert property (@(posedge clk) disable iff (rst)
    $rose(done_irq) |-> $past(rdy_fall));
  // R4: a write while the converter is running starts nothing
  a_r4_busy_write: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && rdy_s && !cvt_start) |=> !cvt_start);
  // R2: a write to base+1 starts nothing
  a_r2_lo_write: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel == SEL_LO && !cvt_start) |=> !cvt_start);

endmodule

// File: tb/tb_adc_byte_bridge.sv
module tb_adc_byte_bridge;
  localparam int          S     = 2;
  localparam int          MINH  = 4;
  localparam logic [15:0] BASE  = 16'h0C40;
  localparam int          CLEN  = 12;

  logic        clk = 1'b0, rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic        cvt_rdy = 1'b0;
  logic [7:0]  cvt_hi = 8'h00;
  logic [1:0]  cvt_lo = 2'b00;
  logic        cvt_start, hi_en_n, lo_en_n, done_irq;
  logic [7:0]  rd_data;

  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  adc_byte_bridge #(.ADDR_W(16), .BASE_ADDR(32'h0C40), .BUS_W(8), .LO_W(2),
                    .SYNC_STAGES(S), .MIN_HIGH(MINH)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .cvt_rdy(cvt_rdy), .cvt_hi(cvt_hi), .cvt_lo(cvt_lo),
    .cvt_start(cvt_start), .hi_en_n(hi_en_n), .lo_en_n(lo_en_n),
    .rd_data(rd_data), .done_irq(done_irq));

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", what, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit   mp[S];
  bit   md, mconv, mseen, mhe, mle, mch, mcl, mdone, merr;
  int   mhc;
  logic [7:0] mrd;

  always @(posedge clk) begin
    bit rs, rise, fall, busy, acc, oconv, och, ncl, nch, eset, sclr;
    int sel;
    logic [15:0] off;
    if (rst) begin
      foreach (mp[i]) mp[i] = 0;
      md = 0; mconv = 0; mseen = 0; mhc = 0; mhe = 0; mle = 0;
      mch = 0; mcl = 0; mdone = 0; merr = 0; mrd = 8'h00;
    end else begin
      rs = mp[S-1]; rise = rs && !md; fall = !rs && md;
      busy = mconv || rs; oconv = mconv; och = mch;
      off = bus_addr - BASE;
      sel = (off == 0) ? 0 : (off == 1) ? 1 : (off == 2) ? 2 : 3;
      acc = bus_rd && !(mch || mcl);
      nch = 0; ncl = 0; eset = 0; sclr = 0;
      if (mch) begin mrd = cvt_hi; mhe = 0; end
      if (mcl) begin mrd = {cvt_lo, 6'b0}; mle = 0; end
      if (acc) begin
        if (sel == 0 || sel == 1) begin
          if (busy) begin mrd = 8'h00; eset = 1; end
          else if (sel == 0) begin mhe = 1; nch = 1; end
          else begin mle = 1; ncl = 1; end
        end else if (sel == 2) begin
          mrd = {rs, mdone, merr, oconv, 4'b0}; sclr = 1;
        end else mrd = 8'h00;
      end
      if (!mconv) begin
        if (bus_wr && sel == 0 && !busy && !bus_rd && !(mch || mcl)) begin
          mconv = 1; mhc = 1; mseen = 0;
        end
      end else if ((mseen || rise) && mhc >= MINH) mconv = 0;
      else begin mseen = mseen || rise; mhc++; end
      if (fall) mdone = 1; else if (och) mdone = 0;
      if (eset) merr = 1; else if (sclr) merr = 0;
      mch = nch; mcl = ncl;
      for (int i = S-1; i > 0; i--) mp[i] = mp[i-1];
      mp[0] = cvt_rdy; md = rs;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk("R1 R3 R4 cvt_start vs model", cvt_start, mconv);
      chk("R5 R7 hi_en_n vs model", hi_en_n, !mhe);
      chk("R6 R7 lo_en_n vs model", lo_en_n, !mle);
      chk("R8 R10 rd_data vs model", rd_data, mrd);
      chk("R9 done_irq vs model", done_irq, mdone);
    end
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired, actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // ---------------- converter environment ----------------
  int lat = 3, ph = 0, ecnt = 0, nconv = 0;
  logic [9:0] last_res = '0;

  always @(negedge clk) begin
    logic [9:0] res;
    if (rst) begin ph = 0; cvt_rdy = 0; end
    else case (ph)
      0: if (cvt_start) begin ecnt = 0; ph = 1; end
      1: begin
        ecnt++;
        if (ecnt >= lat) begin cvt_rdy = 1; cvt_hi = 8'hA5; cvt_lo = 2'b01; ph = 2; ecnt = 0; end
      end
      default: if (!cvt_start) begin
        ecnt++;
        if (ecnt >= CLEN) begin
          res = (nconv == 0) ? 10'h3FF : (nconv == 1) ? 10'h000 : 10'((nconv * 389 + 77) % 1024);
          cvt_hi = res[9:2]; cvt_lo = res[1:0]; cvt_rdy = 0;
          last_res = res; nconv++; ph = 0;
        end
      end
    endcase
  end

  // ---------------- stimulus ----------------
  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic bus_read(input logic [15:0] a);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0;
    @(negedge clk);
  endtask

  task automatic wait_done;
    for (int i = 0; i < 400 && !done_irq; i++) @(negedge clk);
  endtask

  task automatic full_conv(input int l);
    int w;
    lat = l;
    bus_write(BASE, 8'h00);
    w = 1;
    while (cvt_start) begin @(negedge clk); w++; end
    chk("R3 start width at least MIN_HIGH", (w >= MINH), 1);
    wait_done;
    chk("R9 irq after conversion", done_irq, 1);
    bus_read(BASE + 16'd1);
    chk("R6 low bits left-justified", rd_data, {last_res[1:0], 6'b0});
    chk("R9 irq kept by low read", done_irq, 1);
    bus_read(BASE);
    chk("R5 high byte", rd_data, last_res[9:2]);
    chk("R9 irq cleared by high read", done_irq, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R11 reset cvt_start", cvt_start, 0);
    chk("R11 reset hi_en_n", hi_en_n, 1);
    chk("R11 reset lo_en_n", lo_en_n, 1);
    chk("R11 reset rd_data", rd_data, 0);
    chk("R11 reset done_irq", done_irq, 0);
    rst = 0;
    bus_read(BASE + 16'd2);
    chk("R8 idle status", rd_data, 8'h00);
    bus_write(BASE + 16'd1, 8'hFF);
    bus_write(BASE + 16'd7, 8'h12);
    repeat (2) @(negedge clk);
    chk("R2 non-base write ignored", cvt_start, 0);
    bus_write(BASE, 8'h5A);
    chk("R1 start raised", cvt_start, 1);
    bus_read(BASE);
    chk("R7 early read returns zero", rd_data, 8'h00);
    bus_write(BASE, 8'h00);
    while (cvt_start) @(negedge clk);
    repeat (4) @(negedge clk);
    bus_write(BASE, 8'h33);
    chk("R4 busy write ignored", cvt_start, 0);
    bus_read(BASE + 16'd2);
    chk("R8 status busy+err", rd_data, 8'hA0);
    bus_read(BASE + 16'd2);
    chk("R8 err cleared by status read", rd_data[5], 0);
    wait_done;
    chk("R9 done after first conversion", done_irq, 1);
    bus_read(BASE);
    chk("R5 all-ones high byte", rd_data, 8'hFF);
    bus_read(BASE + 16'd1);
    chk("R6 all-ones low bits", rd_data, 8'hC0);
    full_conv(1);
    full_conv(8);
    full_conv(3);
    @(negedge clk); bus_addr = BASE; bus_rd = 1;
    @(negedge clk); @(negedge clk); bus_rd = 0;
    chk("R10 back-to-back strobe ignored", hi_en_n, 1);
    @(negedge clk);
    bus_read(BASE + 16'd9);
    chk("R10 outside window returns zero", rd_data, 8'h00);
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule